// File: doc/BRIEF.md
# ECC Syndrome Post-Processor With Erased-Page Detect

This block sits between a hardware BCH checker and an external BCH decoder (m = 14, t = 4, primitive polynomial 0x4443) on the read path of a flash page. After a page read it takes the seven syndrome bytes and the checker's error flag. It decides whether the page needs correcting at all. A page counts as erased when the syndrome matches a fixed blank-page signature. It also counts as erased when bad-block checking is on and the spare-area written-flag byte has more than four bits set. Pages that do need correcting have their syndrome bytes bit-reversed and handed to the decoder.

When the decoder answers, the block maps each reported error position back onto the page buffer. The low three bits of every position are mirrored. Positions that land in the ECC bytes are dropped, and the others are classed as data-area or spare-area bit flips. Flip requests come out one per cycle. When the job ends, a one-cycle completion pulse carries the number of flips issued, an erased-page flag and an uncorrectable flag. These values hold until the next job starts.

The controller is a five-state machine:
- IDLE waits for `start`. It goes to DONE when correction is skipped (error flag clear, or page erased) and to REQ otherwise.
- REQ presents the reversed syndrome for one cycle and moves to WAIT.
- WAIT holds until `dec_valid`. It goes to DONE on failure or a zero count, and to FLIP otherwise.
- FLIP walks the reported slots, one per cycle, and moves to DONE after the last one.
- DONE pulses `done` and returns to IDLE.

Top module: `synpp_top`

## Requirements
- R1: After reset, `done`, `syn_valid`, `flip_valid`, `blank` and `fail` are 0 and `corr_count` is 0.
- R2: With `syn_err` low at `start`, `done` pulses in the cycle after `start` with `blank`=0, `fail`=0 and `corr_count`=0, and `syn_valid` never rises. This holds even when the syndrome matches the blank signature.
- R3: With `syn_err` high and a syndrome equal to bytes CF 72 FC 1B A9 C7 B9 (byte 0 in `syn_in[7:0]`, byte k in `syn_in[8k+7:8k]`), `done` pulses in the cycle after `start` with `blank`=1 and no decoder request.
- R4: With `syn_err` high, `bbchk_en` high and more than 4 bits set in `spare_flag`, the page is treated as erased, exactly as in R3. A flag with exactly 4 bits set, or any flag while `bbchk_en` is low, does not mark the page erased.
- R5: When correction is needed, `syn_valid` is high for exactly one cycle, in the cycle after `start`. In that cycle each byte of `syn_out` is the same byte of `syn_in` with its bit order reversed.
- R6: For a reported position p, the corrected position q keeps p's bits above bit 2 and has low three bits equal to 7 minus p's low three bits. `flip_bit` equals q's low three bits.
- R7: A q above 4160 issues no flip. A q above 4096 and up to 4160 flips spare byte (q-4096)/8 (`flip_region`=1). Any other q flips data byte q/8 (`flip_region`=0).
- R8: The decoder result is taken on the first `dec_valid` after the request, with no limit on the wait. Slots 0 to `dec_count`-1 of `dec_pos` (slot i in bits 14i+13:14i) are then processed in slot order, one per cycle, starting the cycle after `dec_valid`. Ignored slots take a cycle but assert no `flip_valid`.
- R9: `dec_fail` high, or a `dec_count` above 4, sets `fail`=1, issues no flips, and pulses `done` the cycle after `dec_valid`.
- R10: `done` is a single-cycle pulse in the cycle after the last slot. `corr_count` equals the number of flips actually issued. `blank`, `fail` and `corr_count` hold until the next `start`. A zero `dec_count` finishes with `corr_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing one page read (taken in IDLE only) |
| syn_err | input | 1 | Hardware checker reported a nonzero syndrome |
| bbchk_en | input | 1 | Enables the written-flag erased test |
| syn_in | input | 56 | Seven raw syndrome bytes, byte 0 in the low bits |
| spare_flag | input | 8 | Spare-area written-flag byte |
| syn_out | output | 56 | Bit-reversed syndrome bytes for the decoder |
| syn_valid | output | 1 | Decoder request, one cycle |
| dec_valid | input | 1 | Decoder result valid |
| dec_fail | input | 1 | Decoder reports uncorrectable page |
| dec_count | input | 3 | Number of valid position slots |
| dec_pos | input | 56 | Four 14-bit error positions |
| flip_valid | output | 1 | A bit flip is requested this cycle |
| flip_region | output | 1 | 0 = data area, 1 = spare area |
| flip_byte | output | 11 | Byte address within the region |
| flip_bit | output | 3 | Bit index within the byte |
| done | output | 1 | Job finished, one cycle |
| blank | output | 1 | Page classed as erased |
| fail | output | 1 | Page uncorrectable |
| corr_count | output | 3 | Flips issued for the last job |

## Verification
The hardest cases to reach are the exact edges of position classification: q = 4096 (still data, byte 512), 4097, 4160 and 4161. After the bit-order mirror these come from raw positions 4103, 4102, 4167 and 4166. The bench plays the decoder, so it can place those raw positions straight into the slots. It mixes them with ignored slots in the middle of a burst and with a delayed decoder answer. The erased-flag edge is reached with a written flag of exactly four and of five set bits, and with checking disabled.

// File: rtl/synpp_pkg.sv
package synpp_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_WAIT = 3'd2,
        S_FLIP = 3'd3,
        S_DONE = 3'd4
    } pp_state_t;

    function automatic logic [7:0] mirror8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic int unsigned ones8(input logic [7:0] b);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 8; i++) n += b[i];
        return n;
    endfunction

endpackage

// File: rtl/synpp_prep.sv
module synpp_prep
    import synpp_pkg::*;
#(
    parameter int NSYN = 7,
    parameter logic [NSYN*8-1:0] BLANK_SIG = 56'hB9C7A91BFC72CF,
    parameter int FLAG_MIN = 5
) (
    input  logic [NSYN*8-1:0] syn_raw,
    input  logic [7:0]        flag_byte,
    input  logic              chk_en,
    output logic [NSYN*8-1:0] syn_rev,
    output logic              sig_blank,
    output logic              flag_blank
);
    for (genvar k = 0; k < NSYN; k++) begin : g_rev
        assign syn_rev[k*8 +: 8] = mirror8(syn_raw[k*8 +: 8]);
    end

    assign sig_blank  = (syn_raw == BLANK_SIG);
    assign flag_blank = chk_en && (flag_byte != 8'h00) &&
                        (ones8(flag_byte) >= FLAG_MIN);
endmodule

// File: rtl/synpp_posmap.sv
module synpp_posmap #(
    parameter int POS_W      = 14,
    parameter int DATA_BYTES = 512,
    parameter int PAD_BYTES  = 8,
    localparam int BYTE_W    = POS_W - 3
) (
    input  logic [POS_W-1:0]  pos_raw,
    output logic              ign,
    output logic              spare,
    output logic [BYTE_W-1:0] byte_addr,
    output logic [2:0]        bit_idx
);
    localparam logic [POS_W-1:0] DATA_LIM = POS_W'(DATA_BYTES * 8);
    localparam logic [POS_W-1:0] ALL_LIM  = POS_W'((DATA_BYTES + PAD_BYTES) * 8);

    logic [POS_W-1:0] q;
    logic [POS_W-1:0] off;

    always_comb begin
        q         = {pos_raw[POS_W-1:3], ~pos_raw[2:0]};
        ign       = (q > ALL_LIM);
        spare     = (q > DATA_LIM);
        off       = spare ? (q - DATA_LIM) : q;
        byte_addr = off[POS_W-1:3];
        bit_idx   = off[2:0];
    end
endmodule

// File: rtl/synpp_top.sv
module synpp_top
    import synpp_pkg::*;
#(
    parameter int NSYN       = 7,
    parameter int POS_W      = 14,
    parameter int MAX_ERR    = 4,
    parameter int DATA_BYTES = 512,
    parameter int PAD_BYTES  = 8,
    parameter int FLAG_MIN   = 5,
    localparam int CNT_W     = $clog2(MAX_ERR + 1),
    localparam int IDX_W     = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1,
    localparam int BYTE_W    = POS_W - 3,
    localparam int SYN_W     = NSYN * 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     syn_err,
    input  logic                     bbchk_en,
    input  logic [SYN_W-1:0]         syn_in,
    input  logic [7:0]               spare_flag,
    output logic [SYN_W-1:0]         syn_out,
    output logic                     syn_valid,
    input  logic                     dec_valid,
    input  logic                     dec_fail,
    input  logic [CNT_W-1:0]         dec_count,
    input  logic [MAX_ERR*POS_W-1:0] dec_pos,
    output logic                     flip_valid,
    output logic                     flip_region,
    output logic [BYTE_W-1:0]        flip_byte,
    output logic [2:0]               flip_bit,
    output logic                     done,
    output logic                     blank,
    output logic                     fail,
    output logic [CNT_W-1:0]         corr_count
);
    pp_state_t state, state_nx;

    logic [SYN_W-1:0] syn_rev, syn_q;
    logic             sig_blank, flag_blank, skip_now;
    logic [POS_W-1:0] pos_q [MAX_ERR];
    logic [CNT_W-1:0] cnt_q, count_q;
    logic [IDX_W-1:0] idx_q;
    logic             blank_q, fail_q;
    logic             m_ign, m_spare, last_slot, dec_bad;
    logic [BYTE_W-1:0] m_byte;
    logic [2:0]       m_bit;

    synpp_prep #(.NSYN(NSYN), .FLAG_MIN(FLAG_MIN)) prep_i (
        .syn_raw(syn_in), .flag_byte(spare_flag), .chk_en(bbchk_en),
        .syn_rev(syn_rev), .sig_blank(sig_blank), .flag_blank(flag_blank)
    );

    synpp_posmap #(.POS_W(POS_W), .DATA_BYTES(DATA_BYTES), .PAD_BYTES(PAD_BYTES)) map_i (
        .pos_raw(pos_q[idx_q]), .ign(m_ign), .spare(m_spare),
        .byte_addr(m_byte), .bit_idx(m_bit)
    );

    assign skip_now  = !syn_err || sig_blank || flag_blank;
    assign dec_bad   = dec_fail || (dec_count > CNT_W'(MAX_ERR)) || (dec_count == '0);
    assign last_slot = (CNT_W'(idx_q) == (cnt_q - CNT_W'(1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = skip_now ? S_DONE : S_REQ;
            S_REQ:  state_nx = S_WAIT;
            S_WAIT: if (dec_valid) state_nx = dec_bad ? S_DONE : S_FLIP;
            S_FLIP: if (last_slot) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q   <= '0;
            cnt_q   <= '0;
            count_q <= '0;
            idx_q   <= '0;
            blank_q <= 1'b0;
            fail_q  <= 1'b0;
            for (int i = 0; i < MAX_ERR; i++) pos_q[i] <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    syn_q   <= syn_rev;
                    blank_q <= syn_err && (sig_blank || flag_blank);
                    fail_q  <= 1'b0;
                    count_q <= '0;
                end
                S_WAIT: if (dec_valid) begin
                    cnt_q  <= dec_count;
                    idx_q  <= '0;
                    fail_q <= dec_fail || (dec_count > CNT_W'(MAX_ERR));
                    for (int i = 0; i < MAX_ERR; i++)
                        pos_q[i] <= dec_pos[i*POS_W +: POS_W];
                end
                S_FLIP: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (!m_ign) count_q <= count_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        syn_out     = syn_q;
        syn_valid   = (state == S_REQ);
        flip_valid  = (state == S_FLIP) && !m_ign;
        flip_region = m_spare;
        flip_byte   = m_byte;
        flip_bit    = m_bit;
        done        = (state == S_DONE);
        blank       = blank_q;
        fail        = fail_q;
        corr_count  = count_q;
    end

    // R2: a clean page never reaches the decoder
    a_r2_clean_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !syn_err) |=> (done && !syn_valid && !blank));

    // R3: signature match finishes at once as erased
    a_r3_sig_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && syn_err && sig_blank) |=> (done && blank));

    // R5: decoder request lasts one cycle
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid |=> !syn_valid);

    // R7: issued flips stay inside their region
    a_r7_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
        flip_valid |-> (flip_region ? (flip_byte <= BYTE_W'(PAD_BYTES))
                                    : (flip_byte <= BYTE_W'(DATA_BYTES))));

    // R9: an uncorrectable page carries no flips
    a_r9_fail_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !flip_valid);

    // R10: completion is a single pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/synpp_top_tb_top.sv
`timescale 1ns/1ps
module synpp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, syn_err = 1'b0, bbchk_en = 1'b0;
    logic [55:0] syn_in = '0;
    logic [7:0]  spare_flag = '0;
    logic [55:0] syn_out;
    logic        syn_valid;
    logic        dec_valid = 1'b0, dec_fail = 1'b0;
    logic [2:0]  dec_count = '0;
    logic [55:0] dec_pos = '0;
    logic        flip_valid, flip_region, done, blank, fail;
    logic [10:0] flip_byte;
    logic [2:0]  flip_bit, corr_count;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [55:0] SIG = {8'hB9, 8'hC7, 8'hA9, 8'h1B, 8'hFC, 8'h72, 8'hCF};

    always #2.5 clk = ~clk;

    synpp_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_err(syn_err), .bbchk_en(bbchk_en),
        .syn_in(syn_in), .spare_flag(spare_flag), .syn_out(syn_out), .syn_valid(syn_valid),
        .dec_valid(dec_valid), .dec_fail(dec_fail), .dec_count(dec_count), .dec_pos(dec_pos),
        .flip_valid(flip_valid), .flip_region(flip_region), .flip_byte(flip_byte),
        .flip_bit(flip_bit), .done(done), .blank(blank), .fail(fail), .corr_count(corr_count)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // quiet cycle: no request, no flip, no completion
    task automatic chk_quiet(input string tag);
        chk(tag, "syn_valid", syn_valid, 0);
        chk(tag, "flip_valid", flip_valid, 0);
        chk(tag, "done", done, 0);
    endtask

    function automatic logic [55:0] rev_model(input logic [55:0] s);
        logic [55:0] r;
        for (int k = 0; k < 7; k++)
            for (int j = 0; j < 8; j++) r[k*8 + j] = s[k*8 + 7 - j];
        return r;
    endfunction

    function automatic int ones(input logic [7:0] b);
        int n = 0;
        for (int j = 0; j < 8; j++) if (b[j]) n++;
        return n;
    endfunction

    // one job, cycle by cycle; positions p0..p3
    task automatic job(input string tag, input bit err, input bit chk_on, input logic [55:0] syn,
                       input logic [7:0] flag, input int delay, input bit dfail, input int cnt,
                       input int p0, input int p1, input int p2, input int p3);
        int  p[4];
        bit  skip, exp_blank, exp_fail;
        int  issued;
        p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
        exp_blank = err && ((syn == SIG) || (chk_on && flag != 0 && ones(flag) > 4));
        skip = !err || exp_blank;
        @(negedge clk);
        start = 1; syn_err = err; bbchk_en = chk_on; syn_in = syn; spare_flag = flag;
        @(negedge clk);
        start = 0;
        if (skip) begin
            chk(tag, "done", done, 1);
            chk(tag, "syn_valid", syn_valid, 0);
            chk(tag, "blank", blank, exp_blank);
            chk(tag, "fail", fail, 0);
            chk(tag, "corr_count", corr_count, 0);
            @(negedge clk);
            chk_quiet(tag);
            return;
        end
        chk(tag, "syn_valid", syn_valid, 1);
        chk(tag, "syn_out", syn_out, rev_model(syn));
        chk(tag, "done", done, 0);
        chk(tag, "blank", blank, 0);
        @(negedge clk);
        for (int d = 0; d < delay; d++) begin
            chk_quiet(tag);
            @(negedge clk);
        end
        chk_quiet(tag);
        dec_valid = 1; dec_fail = dfail; dec_count = 3'(cnt);
        for (int i = 0; i < 4; i++) dec_pos[i*14 +: 14] = 14'(p[i]);
        @(negedge clk);
        dec_valid = 0; dec_fail = 0;
        exp_fail = dfail || cnt > 4;
        issued = 0;
        if (!exp_fail && cnt > 0) begin
            for (int i = 0; i < cnt; i++) begin
                int q = (p[i] & ~7) | (7 - (p[i] & 7));
                if (q > 4160) begin
                    chk("R7", "flip_valid(ignored)", flip_valid, 0);
                end else begin
                    int off = (q > 4096) ? q - 4096 : q;
                    chk("R8", "flip_valid", flip_valid, 1);
                    chk("R7", "flip_region", flip_region, q > 4096);
                    chk("R7", "flip_byte", flip_byte, off / 8);
                    chk("R6", "flip_bit", flip_bit, off % 8);
                    issued++;
                end
                chk(tag, "done", done, 0);
                @(negedge clk);
            end
        end
        chk("R10", "done", done, 1);
        chk(tag, "fail", fail, exp_fail);
        chk("R10", "corr_count", corr_count, issued);
        chk(tag, "flip_valid", flip_valid, 0);
        @(negedge clk);
        chk_quiet("R10");
        chk("R10", "corr_count hold", corr_count, issued);
        chk("R10", "fail hold", fail, exp_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", done, 0);
        chk("R1", "syn_valid", syn_valid, 0);
        chk("R1", "flip_valid", flip_valid, 0);
        chk("R1", "blank", blank, 0);
        chk("R1", "fail", fail, 0);
        chk("R1", "corr_count", corr_count, 0);
        rst_n = 1;
        @(negedge clk);
        // R2: clean page, even with blank signature
        job("R2", 0, 1, SIG, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
        job("R3", 1, 0, SIG, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        // R4 erased flag thresholds
        job("R4", 1, 1, 56'h0123456789ABCD, 8'h1F, 0, 0, 0, 0, 0, 0, 0);
        job("R4", 1, 1, 56'h0123456789ABCD, 8'h0F, 0, 0, 1, 100, 0, 0, 0);
        job("R4", 1, 0, 56'h00FF00FF00FF01, 8'hFF, 0, 0, 1, 9, 0, 0, 0);
        // R5/R6/R7 boundaries: q = 7, 4088, 4096, 4097
        job("R5", 1, 1, 56'h80402010080402, 8'h00, 0, 0, 4, 0, 4095, 4103, 4102);
        // R7/R8: q = 4160, ignored 4161, ignored large, data; delayed decoder
        job("R8", 1, 1, 56'h11223344556677, 8'h01, 3, 0, 4, 4167, 4166, 8000, 1234);
        // R9 decoder failure and over-count
        job("R9", 1, 1, 56'hA5A5A5A5A5A5A5, 8'h00, 0, 1, 2, 10, 20, 0, 0);
        job("R9", 1, 1, 56'h5A5A5A5A5A5A5A, 8'h00, 1, 0, 6, 10, 20, 30, 40);
        // R10 zero count
        job("R10", 1, 1, 56'h0F0F0F0F0F0F0F, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        // R2 again after a failed job: results cleared
        job("R2", 0, 0, 56'h0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule